// File: doc/BRIEF.md
# Protected Bidirectional Bus Bridge

This block sits between a processor's local bus and a shared internal peripheral bus. Going downstream it carries processor loads and stores onto the shared bus. Going upstream it carries reads and writes from an alternate bus master onto the local bus. It handles one transaction at a time.

Before a processor access is forwarded downstream, it is tested against four protection regions. Each region compares the access address and its attributes: read or write, and supervisor or user. An access that breaks a region's permissions is not forwarded. The processor receives an error response instead. When show mode is on, processor accesses to local-only resources are copied onto the shared bus as single-cycle, write-only show cycles.

The bridge treats its two resets differently. A soft reset abandons in-flight traffic but keeps the configuration. A hard reset reloads the configuration defaults. Both resets are passed on to the local bus side. During hard reset, a reset configuration word is also passed through.

Top module: `prot_bus_bridge`

## Requirements
- R1: When the slave-mode bit is 0, the alternate master is never served. `alt_rdy` stays low, and an `alt_req` produces no `loc_req` and no `alt_ack`.
- R2: When the slave-mode bit is 1 and the bridge is idle, an accepted alternate access appears once on the local bus with the same address, write flag and write data. The local bus read data then returns on `alt_rdata` with a one-cycle `alt_ack`.
- R3: Region configuration `cfg_flags` bits are: [0] enable, [1] reads allowed, [2] writes allowed, [3] supervisor only. A region is hit when the address equals `cfg_base` on every bit where `cfg_mask` is 1. An access breaks a hit region in three cases: it is a write with bit 2 clear, it is a read with bit 1 clear, or it is a user access (`cpu_sup`=0) with bit 3 set.
- R4: A processor access that breaks any enabled hit region never reaches the shared bus. `cpu_ack` and `cpu_err` are both raised for one cycle, two clock edges after the accepting edge, and `cpu_rdata` is zero.
- R5: A shared-bus access that breaks no region, including one that hits no enabled region, is forwarded with the same address and write flag. The shared-bus write data carries `cpu_wdata` for writes and zero for reads. `cpu_ack` returns the shared-bus read data with `cpu_err` low.
- R6: With show mode on, a local-only access (`cpu_local`=1) causes exactly one cycle of `shb_req` with `shb_mirror`=1 and `shb_write`=1. That cycle carries the access address, and the write data for writes or zero for reads. `cpu_rdy` is low for that one cycle only, and no processor response is given.
- R7: With show mode off, a local-only access causes no shared-bus cycle and leaves `cpu_rdy` high.
- R8: Only one transaction is outstanding at a time. While one is in progress, `cpu_rdy` and `alt_rdy` are low. When both masters request in the same idle cycle, the processor wins.
- R9: A soft reset returns the bridge to idle. The pending access is dropped and never answered. Region and mode settings keep their values.
- R10: A hard reset disables all regions, turns show mode off and selects master mode.
- R11: `loc_hard_rst` and `loc_soft_rst` follow `hard_rst` and `soft_rst`. `rcw_out` equals `rcw_in` while `hard_rst` is high and is zero otherwise.
- R12: When regions overlap, an access that one region permits and another forbids is treated as a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, shared-bus side |
| soft_rst | input | 1 | Synchronous soft reset, shared-bus side |
| rcw_in | input | 16 | Reset configuration word from the shared bus |
| loc_hard_rst | output | 1 | Hard reset forwarded to the local bus |
| loc_soft_rst | output | 1 | Soft reset forwarded to the local bus |
| rcw_out | output | 16 | Reset configuration word to the local bus |
| cfg_we | input | 1 | Region configuration write strobe |
| cfg_idx | input | 2 | Region selected by the write |
| cfg_base | input | 32 | Region base address |
| cfg_mask | input | 32 | Region compare mask |
| cfg_flags | input | 4 | Region enable and permission bits |
| mode_we | input | 1 | Mode register write strobe |
| mode_show | input | 1 | Show-cycle enable |
| mode_slave | input | 1 | Slave mode enable |
| cpu_req | input | 1 | Processor request strobe |
| cpu_rdy | output | 1 | Bridge can accept a processor request |
| cpu_addr | input | 32 | Processor address |
| cpu_write | input | 1 | Processor write (1) or read (0) |
| cpu_sup | input | 1 | Processor supervisor privilege |
| cpu_local | input | 1 | Access targets a local-only resource |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ack | output | 1 | Processor response strobe |
| cpu_err | output | 1 | Response carries a protection error |
| cpu_rdata | output | 32 | Processor read data |
| shb_req | output | 1 | Shared-bus request |
| shb_mirror | output | 1 | Shared-bus cycle is a show cycle |
| shb_addr | output | 32 | Shared-bus address |
| shb_write | output | 1 | Shared-bus write flag |
| shb_wdata | output | 32 | Shared-bus write data |
| shb_ack | input | 1 | Shared-bus completion |
| shb_rdata | input | 32 | Shared-bus read data |
| alt_req | input | 1 | Alternate master request strobe |
| alt_rdy | output | 1 | Bridge can accept an alternate request |
| alt_addr | input | 32 | Alternate master address |
| alt_write | input | 1 | Alternate master write flag |
| alt_wdata | input | 32 | Alternate master write data |
| alt_ack | output | 1 | Alternate master response strobe |
| alt_rdata | output | 32 | Alternate master read data |
| loc_req | output | 1 | Local-bus request for an upstream access |
| loc_addr | output | 32 | Local-bus address |
| loc_write | output | 1 | Local-bus write flag |
| loc_wdata | output | 32 | Local-bus write data |
| loc_ack | input | 1 | Local-bus completion |
| loc_rdata | input | 32 | Local-bus read data |

## Verification
The assertions check rules that hold on every cycle:
- The shared and local requests are never raised together.
- A show cycle lasts one cycle and is always a write.
- An error response has no shared-bus request in the cycle before it.
- Configuration holds steady across a soft reset, and the bridge is quiet right after one.

Some behaviour can only be shown by bench scenarios:
- Whether a given address and attribute mix is permitted under overlapping regions.
- That forwarded fields and returned data arrive unchanged.
- The exact error latency.
- Dropping a pending access on soft reset, and restoring defaults on hard reset.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    parameter int ADDR_W  = 32;
    parameter int DATA_W  = 32;
    parameter int NUM_RGN = 4;
    parameter int RCW_W   = 16;
    parameter int FLAG_W  = 4;

    localparam int RGN_IDX_W = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1;

    // flag bit positions in a region configuration write
    localparam int FL_EN  = 0;
    localparam int FL_RD  = 1;
    localparam int FL_WR  = 2;
    localparam int FL_SUP = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FORWARD,
        ST_WAIT_ACK,
        ST_ERROR,
        ST_MIRROR
    } br_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              sup;
    } br_access_t;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        logic              en;
        logic              rd_ok;
        logic              wr_ok;
        logic              sup_only;
    } rgn_cfg_t;

    function automatic logic rgn_hit(input rgn_cfg_t r, input logic [ADDR_W-1:0] a);
        return r.en && (((a ^ r.base) & r.mask) == '0);
    endfunction

    function automatic logic rgn_breaks(input rgn_cfg_t r, input br_access_t acc);
        logic bad_dir;
        bad_dir = acc.write ? !r.wr_ok : !r.rd_ok;
        return rgn_hit(r, acc.addr) && (bad_dir || (r.sup_only && !acc.sup));
    endfunction

endpackage

// File: rtl/bridge_rst_fwd.sv
module bridge_rst_fwd
    import bridge_pkg::*;
(
    input  logic             hard_rst,
    input  logic             soft_rst,
    input  logic [RCW_W-1:0] rcw_in,
    output logic             loc_hard_rst,
    output logic             loc_soft_rst,
    output logic [RCW_W-1:0] rcw_out
);

    assign loc_hard_rst = hard_rst;
    assign loc_soft_rst = soft_rst;
    assign rcw_out      = hard_rst ? rcw_in : '0;

endmodule

// File: rtl/bridge_rgn_file.sv
module bridge_rgn_file
    import bridge_pkg::*;
(
    input  logic                 clk,
    input  logic                 hard_rst,
    input  logic                 soft_rst,
    input  logic                 cfg_we,
    input  logic [RGN_IDX_W-1:0] cfg_idx,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [ADDR_W-1:0]    cfg_mask,
    input  logic [FLAG_W-1:0]    cfg_flags,
    input  logic                 mode_we,
    input  logic                 mode_show,
    input  logic                 mode_slave,
    input  br_access_t           chk_acc,
    output logic                 viol,
    output logic                 show_en,
    output logic                 slave_en
);

    rgn_cfg_t           rgn_q [NUM_RGN];
    logic [NUM_RGN-1:0] breaks;
    logic               cfg_ok;

    // configuration writes are not taken while either reset is held
    assign cfg_ok = !hard_rst && !soft_rst;

    always_ff @(posedge clk) begin
        if (hard_rst) begin
            for (int i = 0; i < NUM_RGN; i++) begin
                rgn_q[i] <= '0;
            end
            show_en  <= 1'b0;
            slave_en <= 1'b0;
        end else if (cfg_ok) begin
            for (int i = 0; i < NUM_RGN; i++) begin
                if (cfg_we && (cfg_idx == RGN_IDX_W'(i))) begin
                    rgn_q[i].base     <= cfg_base;
                    rgn_q[i].mask     <= cfg_mask;
                    rgn_q[i].en       <= cfg_flags[FL_EN];
                    rgn_q[i].rd_ok    <= cfg_flags[FL_RD];
                    rgn_q[i].wr_ok    <= cfg_flags[FL_WR];
                    rgn_q[i].sup_only <= cfg_flags[FL_SUP];
                end
            end
            if (mode_we) begin
                show_en  <= mode_show;
                slave_en <= mode_slave;
            end
        end
    end

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        assign breaks[g] = rgn_breaks(rgn_q[g], chk_acc);

        // R9: settings survive a soft reset
        p_soft_keeps_cfg_r9: assert property (@(posedge clk) disable iff (hard_rst)
            soft_rst |=> $stable(rgn_q[g]));
    end

    assign viol = |breaks;

    p_soft_keeps_mode_r9: assert property (@(posedge clk) disable iff (hard_rst)
        soft_rst |=> ($stable(show_en) && $stable(slave_en)));

endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              hard_rst,
    input  logic              soft_rst,
    input  logic              show_en,
    input  logic              slave_en,
    input  logic              viol,
    output br_access_t        acc,
    input  logic              cpu_req,
    output logic              cpu_rdy,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_write,
    input  logic              cpu_sup,
    input  logic              cpu_local,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic              cpu_err,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              shb_req,
    output logic              shb_mirror,
    output logic [ADDR_W-1:0] shb_addr,
    output logic              shb_write,
    output logic [DATA_W-1:0] shb_wdata,
    input  logic              shb_ack,
    input  logic [DATA_W-1:0] shb_rdata,
    input  logic              alt_req,
    output logic              alt_rdy,
    input  logic [ADDR_W-1:0] alt_addr,
    input  logic              alt_write,
    input  logic [DATA_W-1:0] alt_wdata,
    output logic              alt_ack,
    output logic [DATA_W-1:0] alt_rdata,
    output logic              loc_req,
    output logic [ADDR_W-1:0] loc_addr,
    output logic              loc_write,
    output logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_ack,
    input  logic [DATA_W-1:0] loc_rdata
);

    br_state_e  state_q;
    br_access_t acc_q;
    logic       up_q;
    logic       cpu_take;
    logic       alt_take;
    logic       any_rst;

    assign any_rst  = hard_rst || soft_rst;
    assign cpu_rdy  = (state_q == ST_IDLE);
    assign alt_rdy  = (state_q == ST_IDLE) && slave_en && !cpu_req;
    assign cpu_take = cpu_req && cpu_rdy;
    assign alt_take = alt_req && alt_rdy;

    always_ff @(posedge clk) begin
        if (any_rst) begin
            state_q   <= ST_IDLE;
            acc_q     <= '0;
            up_q      <= 1'b0;
            cpu_ack   <= 1'b0;
            cpu_err   <= 1'b0;
            cpu_rdata <= '0;
            alt_ack   <= 1'b0;
            alt_rdata <= '0;
        end else begin
            cpu_ack <= 1'b0;
            cpu_err <= 1'b0;
            alt_ack <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_take) begin
                        acc_q.addr  <= cpu_addr;
                        acc_q.wdata <= cpu_write ? cpu_wdata : '0;
                        acc_q.write <= cpu_write;
                        acc_q.sup   <= cpu_sup;
                        up_q        <= 1'b0;
                        if (!cpu_local) begin
                            state_q <= ST_CHECK;
                        end else if (show_en) begin
                            state_q <= ST_MIRROR;
                        end
                    end else if (alt_take) begin
                        acc_q.addr  <= alt_addr;
                        acc_q.wdata <= alt_wdata;
                        acc_q.write <= alt_write;
                        acc_q.sup   <= 1'b0;
                        up_q        <= 1'b1;
                        state_q     <= ST_FORWARD;
                    end
                end
                ST_CHECK:   state_q <= viol ? ST_ERROR : ST_FORWARD;
                ST_FORWARD: state_q <= ST_WAIT_ACK;
                ST_WAIT_ACK: begin
                    if (!up_q && shb_ack) begin
                        cpu_ack   <= 1'b1;
                        cpu_rdata <= shb_rdata;
                        state_q   <= ST_IDLE;
                    end else if (up_q && loc_ack) begin
                        alt_ack   <= 1'b1;
                        alt_rdata <= loc_rdata;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_ERROR: begin
                    cpu_ack   <= 1'b1;
                    cpu_err   <= 1'b1;
                    cpu_rdata <= '0;
                    state_q   <= ST_IDLE;
                end
                ST_MIRROR:  state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    assign acc        = acc_q;
    assign shb_mirror = (state_q == ST_MIRROR);
    assign shb_req    = ((state_q == ST_FORWARD) && !up_q) || shb_mirror;
    assign shb_addr   = acc_q.addr;
    assign shb_write  = acc_q.write || shb_mirror;
    assign shb_wdata  = acc_q.wdata;
    assign loc_req    = (state_q == ST_FORWARD) && up_q;
    assign loc_addr   = acc_q.addr;
    assign loc_write  = acc_q.write;
    assign loc_wdata  = acc_q.wdata;

    // R8: never two targets at once, never two responses at once
    p_one_target_r8: assert property (@(posedge clk) disable iff (any_rst)
        $onehot0({shb_req, loc_req}));
    p_one_resp_r8: assert property (@(posedge clk) disable iff (any_rst)
        !(cpu_ack && alt_ack));
    // R6: a show cycle is a single write cycle
    p_mirror_single_r6: assert property (@(posedge clk) disable iff (any_rst)
        (shb_req && shb_mirror) |=> !shb_req);
    p_mirror_write_r6: assert property (@(posedge clk) disable iff (any_rst)
        shb_mirror |-> shb_write);
    // R4: an error answer is never preceded by a shared-bus request
    p_err_no_fwd_r4: assert property (@(posedge clk) disable iff (any_rst)
        cpu_err |-> ($past(!shb_req) && cpu_ack && (cpu_rdata == '0)));
    // R1: without slave mode nothing reaches the local bus
    p_master_no_loc_r1: assert property (@(posedge clk) disable iff (any_rst)
        (!slave_en && $past(!slave_en) && $past(!loc_req)) |-> !alt_rdy);

endmodule

// File: rtl/prot_bus_bridge.sv
module prot_bus_bridge
    import bridge_pkg::*;
(
    input  logic                 clk,
    input  logic                 hard_rst,
    input  logic                 soft_rst,
    input  logic [RCW_W-1:0]     rcw_in,
    output logic                 loc_hard_rst,
    output logic                 loc_soft_rst,
    output logic [RCW_W-1:0]     rcw_out,
    input  logic                 cfg_we,
    input  logic [RGN_IDX_W-1:0] cfg_idx,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [ADDR_W-1:0]    cfg_mask,
    input  logic [FLAG_W-1:0]    cfg_flags,
    input  logic                 mode_we,
    input  logic                 mode_show,
    input  logic                 mode_slave,
    input  logic                 cpu_req,
    output logic                 cpu_rdy,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic                 cpu_write,
    input  logic                 cpu_sup,
    input  logic                 cpu_local,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic                 cpu_ack,
    output logic                 cpu_err,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 shb_req,
    output logic                 shb_mirror,
    output logic [ADDR_W-1:0]    shb_addr,
    output logic                 shb_write,
    output logic [DATA_W-1:0]    shb_wdata,
    input  logic                 shb_ack,
    input  logic [DATA_W-1:0]    shb_rdata,
    input  logic                 alt_req,
    output logic                 alt_rdy,
    input  logic [ADDR_W-1:0]    alt_addr,
    input  logic                 alt_write,
    input  logic [DATA_W-1:0]    alt_wdata,
    output logic                 alt_ack,
    output logic [DATA_W-1:0]    alt_rdata,
    output logic                 loc_req,
    output logic [ADDR_W-1:0]    loc_addr,
    output logic                 loc_write,
    output logic [DATA_W-1:0]    loc_wdata,
    input  logic                 loc_ack,
    input  logic [DATA_W-1:0]    loc_rdata
);

    br_access_t acc;
    logic       viol;
    logic       show_en;
    logic       slave_en;

    bridge_rst_fwd u_rst (
        .hard_rst     (hard_rst),
        .soft_rst     (soft_rst),
        .rcw_in       (rcw_in),
        .loc_hard_rst (loc_hard_rst),
        .loc_soft_rst (loc_soft_rst),
        .rcw_out      (rcw_out)
    );

    bridge_rgn_file u_rgn (
        .clk        (clk),
        .hard_rst   (hard_rst),
        .soft_rst   (soft_rst),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_base   (cfg_base),
        .cfg_mask   (cfg_mask),
        .cfg_flags  (cfg_flags),
        .mode_we    (mode_we),
        .mode_show  (mode_show),
        .mode_slave (mode_slave),
        .chk_acc    (acc),
        .viol       (viol),
        .show_en    (show_en),
        .slave_en   (slave_en)
    );

    bridge_ctrl u_ctrl (
        .clk        (clk),
        .hard_rst   (hard_rst),
        .soft_rst   (soft_rst),
        .show_en    (show_en),
        .slave_en   (slave_en),
        .viol       (viol),
        .acc        (acc),
        .cpu_req    (cpu_req),
        .cpu_rdy    (cpu_rdy),
        .cpu_addr   (cpu_addr),
        .cpu_write  (cpu_write),
        .cpu_sup    (cpu_sup),
        .cpu_local  (cpu_local),
        .cpu_wdata  (cpu_wdata),
        .cpu_ack    (cpu_ack),
        .cpu_err    (cpu_err),
        .cpu_rdata  (cpu_rdata),
        .shb_req    (shb_req),
        .shb_mirror (shb_mirror),
        .shb_addr   (shb_addr),
        .shb_write  (shb_write),
        .shb_wdata  (shb_wdata),
        .shb_ack    (shb_ack),
        .shb_rdata  (shb_rdata),
        .alt_req    (alt_req),
        .alt_rdy    (alt_rdy),
        .alt_addr   (alt_addr),
        .alt_write  (alt_write),
        .alt_wdata  (alt_wdata),
        .alt_ack    (alt_ack),
        .alt_rdata  (alt_rdata),
        .loc_req    (loc_req),
        .loc_addr   (loc_addr),
        .loc_write  (loc_write),
        .loc_wdata  (loc_wdata),
        .loc_ack    (loc_ack),
        .loc_rdata  (loc_rdata)
    );

    // R9: right after a soft reset nothing is requested or answered
    p_soft_quiet_r9: assert property (@(posedge clk) disable iff (hard_rst)
        soft_rst |=> (!shb_req && !loc_req && !cpu_ack && !alt_ack));
    // R4: an error always travels with an acknowledge
    p_err_with_ack_r4: assert property (@(posedge clk) disable iff (hard_rst || soft_rst)
        cpu_err |-> cpu_ack);

endmodule

// File: tb/sim_prot_bus_bridge.sv
module sim_prot_bus_bridge;
    import bridge_pkg::*;

    localparam int CLK_P = 10;

    logic                 clk = 1'b0;
    logic                 hard_rst = 1'b1, soft_rst = 1'b0;
    logic [RCW_W-1:0]     rcw_in = 16'hC3A5;
    logic                 loc_hard_rst, loc_soft_rst;
    logic [RCW_W-1:0]     rcw_out;
    logic                 cfg_we = 0;
    logic [RGN_IDX_W-1:0] cfg_idx = '0;
    logic [ADDR_W-1:0]    cfg_base = '0, cfg_mask = '0;
    logic [FLAG_W-1:0]    cfg_flags = '0;
    logic                 mode_we = 0, mode_show = 0, mode_slave = 0;
    logic                 cpu_req = 0, cpu_rdy, cpu_write = 0, cpu_sup = 0, cpu_local = 0;
    logic [ADDR_W-1:0]    cpu_addr = '0;
    logic [DATA_W-1:0]    cpu_wdata = '0, cpu_rdata;
    logic                 cpu_ack, cpu_err;
    logic                 shb_req, shb_mirror, shb_write, shb_ack = 0;
    logic [ADDR_W-1:0]    shb_addr;
    logic [DATA_W-1:0]    shb_wdata, shb_rdata = '0;
    logic                 alt_req = 0, alt_rdy, alt_write = 0, alt_ack;
    logic [ADDR_W-1:0]    alt_addr = '0;
    logic [DATA_W-1:0]    alt_wdata = '0, alt_rdata;
    logic                 loc_req, loc_write, loc_ack = 0;
    logic [ADDR_W-1:0]    loc_addr;
    logic [DATA_W-1:0]    loc_wdata, loc_rdata = '0;

    int checks = 0, errors = 0;
    int fwd_cnt = 0, mir_cnt = 0, loc_cnt = 0, ack_cnt = 0;
    logic [ADDR_W-1:0] last_saddr = '0;
    logic [DATA_W-1:0] last_swdata = '0;
    logic              last_swrite = 0;
    logic              hold_tgt = 0;

    logic [ADDR_W-1:0] b_base [NUM_RGN];
    logic [ADDR_W-1:0] b_mask [NUM_RGN];
    logic [FLAG_W-1:0] b_flag [NUM_RGN];

    always #(CLK_P/2) clk = ~clk;

    prot_bus_bridge u0 (.*);

    function automatic logic [DATA_W-1:0] shb_model(input logic [ADDR_W-1:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction
    function automatic logic [DATA_W-1:0] loc_model(input logic [ADDR_W-1:0] a);
        return ~a + 32'h0000_1357;
    endfunction
    function automatic logic ref_viol(input logic [ADDR_W-1:0] a, input logic w, input logic s);
        logic v = 1'b0;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (b_flag[i][0] && (((a ^ b_base[i]) & b_mask[i]) == '0)) begin
                if (w ? !b_flag[i][2] : !b_flag[i][1]) v = 1'b1;
                if (b_flag[i][3] && !s) v = 1'b1;
            end
        end
        return v;
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor
    initial forever begin
        @(negedge clk);
        if (shb_req && !shb_mirror) begin
            fwd_cnt++; last_saddr = shb_addr; last_swdata = shb_wdata; last_swrite = shb_write;
        end
        if (shb_req && shb_mirror) mir_cnt++;
        if (loc_req) loc_cnt++;
        if (cpu_ack || alt_ack) ack_cnt++;
    end

    // shared-bus target
    initial forever begin
        @(negedge clk);
        if (shb_req && !shb_mirror && !hold_tgt) begin
            automatic logic [ADDR_W-1:0] a = shb_addr;
            repeat (($urandom % 3) + 1) @(negedge clk);
            shb_ack = 1; shb_rdata = shb_model(a);
            @(negedge clk);
            shb_ack = 0;
        end
    end

    // local-bus target for upstream accesses
    initial forever begin
        @(negedge clk);
        if (loc_req) begin
            automatic logic [ADDR_W-1:0] a = loc_addr;
            repeat (($urandom % 3) + 1) @(negedge clk);
            loc_ack = 1; loc_rdata = loc_model(a);
            @(negedge clk);
            loc_ack = 0;
        end
    end

    task automatic set_rgn(input int i, input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] m,
                           input logic [FLAG_W-1:0] f);
        @(negedge clk);
        cfg_we = 1; cfg_idx = RGN_IDX_W'(i); cfg_base = b; cfg_mask = m; cfg_flags = f;
        b_base[i] = b; b_mask[i] = m; b_flag[i] = f;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_mode(input logic show, input logic slave);
        @(negedge clk);
        mode_we = 1; mode_show = show; mode_slave = slave;
        @(negedge clk);
        mode_we = 0;
    endtask

    task automatic clear_model();
        for (int i = 0; i < NUM_RGN; i++) begin
            b_base[i] = '0; b_mask[i] = '0; b_flag[i] = '0;
        end
    endtask

    // issues a processor access; returns response and negedges to response
    task automatic cpu_access(input logic [ADDR_W-1:0] a, input logic w, input logic s,
                              input logic lcl, input logic [DATA_W-1:0] d,
                              output logic got, output logic err,
                              output logic [DATA_W-1:0] rd, output int lat);
        @(negedge clk);
        while (!cpu_rdy) @(negedge clk);
        cpu_req = 1; cpu_addr = a; cpu_write = w; cpu_sup = s; cpu_local = lcl; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 0;
        got = 0; err = 0; rd = '0; lat = 0;
        if (lcl) return;
        while (lat < 40 && !got) begin
            @(negedge clk);
            lat++;
            if (cpu_ack) begin got = 1; err = cpu_err; rd = cpu_rdata; end
        end
    endtask

    task automatic alt_access(input logic [ADDR_W-1:0] a, input logic w,
                              input logic [DATA_W-1:0] d,
                              output logic got, output logic [DATA_W-1:0] rd);
        int n = 0;
        @(negedge clk);
        while (!alt_rdy && n < 40) begin @(negedge clk); n++; end
        alt_req = 1; alt_addr = a; alt_write = w; alt_wdata = d;
        @(negedge clk);
        alt_req = 0;
        got = 0; rd = '0; n = 0;
        while (n < 40 && !got) begin
            @(negedge clk);
            n++;
            if (alt_ack) begin got = 1; rd = alt_rdata; end
        end
    endtask

    task automatic do_hard_reset();
        @(negedge clk);
        hard_rst = 1;
        repeat (2) @(negedge clk);
        hard_rst = 0;
        clear_model();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic got, err;
        logic [DATA_W-1:0] rd;
        int lat, f0, m0, l0, a0;
        void'($urandom(32'd1234));
        clear_model();

        // R11 during hard reset
        repeat (2) @(negedge clk);
        chk(loc_hard_rst == 1, "R11", "loc_hard_rst", loc_hard_rst, 1);
        chk(rcw_out == rcw_in, "R11", "rcw pass", rcw_out, rcw_in);
        @(negedge clk);
        hard_rst = 0;
        @(negedge clk);
        // R10 reset state
        chk(cpu_rdy == 1, "R10", "cpu_rdy after reset", cpu_rdy, 1);
        chk(alt_rdy == 0, "R10", "master mode after reset", alt_rdy, 0);
        chk(!shb_req && !cpu_ack, "R10", "idle outputs", {shb_req, cpu_ack}, 0);
        chk(rcw_out == 0, "R11", "rcw zero out of reset", rcw_out, 0);
        soft_rst = 1;
        @(negedge clk);
        chk(loc_soft_rst == 1 && loc_hard_rst == 0, "R11", "soft fwd",
            {loc_soft_rst, loc_hard_rst}, 2'b10);
        chk(rcw_out == 0, "R11", "rcw zero in soft reset", rcw_out, 0);
        soft_rst = 0;

        // R5 no region: forwarded unchanged
        f0 = fwd_cnt;
        cpu_access(32'h1000_0040, 1, 0, 0, 32'hDEAD_BEEF, got, err, rd, lat);
        chk(got && !err, "R5", "write ok", {got, err}, 2'b10);
        chk(last_saddr == 32'h1000_0040 && last_swrite && last_swdata == 32'hDEAD_BEEF,
            "R5", "forwarded write fields", last_swdata, 32'hDEAD_BEEF);
        cpu_access(32'h1000_0080, 0, 0, 0, 32'h1111_2222, got, err, rd, lat);
        chk(got && !err && rd == shb_model(32'h1000_0080), "R5", "read data", rd,
            shb_model(32'h1000_0080));
        chk(!last_swrite && last_swdata == 0, "R5", "read wdata zero", last_swdata, 0);
        chk(fwd_cnt == f0 + 2, "R5", "forward count", fwd_cnt, f0 + 2);

        // R3 R4 violations
        set_rgn(0, 32'h2000_0000, 32'hFFFF_0000, 4'b0011); // read-only
        f0 = fwd_cnt;
        cpu_access(32'h2000_1234, 1, 1, 0, 32'h55, got, err, rd, lat);
        chk(got && err, "R4", "write to read-only errs", {got, err}, 2'b11);
        chk(lat == 2, "R4", "error latency", lat, 2);
        chk(rd == 0, "R4", "error rdata zero", rd, 0);
        chk(fwd_cnt == f0, "R4", "violating not forwarded", fwd_cnt, f0);
        cpu_access(32'h2000_1234, 0, 0, 0, 0, got, err, rd, lat);
        chk(got && !err, "R3", "read permitted", {got, err}, 2'b10);
        set_rgn(1, 32'h3000_0000, 32'hFFFF_F000, 4'b1111); // supervisor only
        cpu_access(32'h3000_0100, 0, 0, 0, 0, got, err, rd, lat);
        chk(err, "R3", "user to supervisor region errs", err, 1);
        cpu_access(32'h3000_0100, 0, 1, 0, 0, got, err, rd, lat);
        chk(got && !err, "R3", "supervisor permitted", {got, err}, 2'b10);
        set_rgn(2, 32'h3000_2000, 32'hFFFF_F000, 4'b0110); // disabled, forbids all reads? no: rd,wr set but en=0
        set_rgn(2, 32'h4000_0000, 32'hFFFF_FF00, 4'b0000); // disabled region ignored
        cpu_access(32'h4000_0010, 1, 0, 0, 32'h9, got, err, rd, lat);
        chk(got && !err, "R3", "disabled region ignored", {got, err}, 2'b10);

        // R12 overlap
        set_rgn(2, 32'h5000_0000, 32'hFF00_0000, 4'b0111);
        set_rgn(3, 32'h5000_4000, 32'hFFFF_F000, 4'b0011);
        cpu_access(32'h5000_4008, 1, 0, 0, 32'h7, got, err, rd, lat);
        chk(err, "R12", "overlap forbids write", err, 1);
        cpu_access(32'h5001_0008, 1, 0, 0, 32'h7, got, err, rd, lat);
        chk(got && !err, "R12", "outer region permits", {got, err}, 2'b10);

        // R6 mirror
        set_mode(1, 0);
        @(negedge clk);
        cpu_req = 1; cpu_addr = 32'h0000_0F00; cpu_write = 1; cpu_local = 1; cpu_wdata = 32'hABCD;
        @(negedge clk);
        cpu_req = 0;
        chk(shb_req && shb_mirror && shb_write, "R6", "mirror cycle", {shb_req, shb_mirror, shb_write}, 3'b111);
        chk(shb_addr == 32'h0000_0F00 && shb_wdata == 32'hABCD, "R6", "mirror fields", shb_wdata, 32'hABCD);
        chk(cpu_rdy == 0, "R6", "one stall cycle", cpu_rdy, 0);
        @(negedge clk);
        chk(!shb_req && cpu_rdy && !cpu_ack, "R6", "mirror done", {shb_req, cpu_rdy, cpu_ack}, 3'b010);
        cpu_req = 1; cpu_write = 0; cpu_addr = 32'h0000_0F04;
        @(negedge clk);
        cpu_req = 0;
        chk(shb_mirror && shb_write && shb_wdata == 0, "R6", "read mirror", shb_wdata, 0);
        cpu_local = 0;

        // R7 show off
        set_mode(0, 0);
        m0 = mir_cnt;
        @(negedge clk);
        cpu_req = 1; cpu_local = 1; cpu_write = 1;
        @(negedge clk);
        cpu_req = 0;
        chk(!shb_req && cpu_rdy, "R7", "no mirror when off", {shb_req, cpu_rdy}, 2'b01);
        repeat (2) @(negedge clk);
        chk(mir_cnt == m0, "R7", "mirror count", mir_cnt, m0);
        cpu_local = 0;

        // R1 master mode
        l0 = loc_cnt; a0 = ack_cnt;
        @(negedge clk);
        alt_req = 1; alt_addr = 32'h6000_0000;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(alt_rdy == 0, "R1", "alt_rdy low", alt_rdy, 0);
        end
        alt_req = 0;
        chk(loc_cnt == l0 && ack_cnt == a0, "R1", "no upstream activity", loc_cnt, l0);

        // R2 slave mode
        set_mode(0, 1);
        alt_access(32'h6000_0044, 0, 0, got, rd);
        chk(got && rd == loc_model(32'h6000_0044), "R2", "upstream read", rd, loc_model(32'h6000_0044));
        alt_access(32'h6000_0048, 1, 32'h1234_5678, got, rd);
        chk(got && loc_cnt == l0 + 2, "R2", "upstream write count", loc_cnt, l0 + 2);

        // R8 priority and busy
        @(negedge clk);
        while (!cpu_rdy) @(negedge clk);
        cpu_req = 1; cpu_addr = 32'h1000_0000; cpu_write = 0; cpu_sup = 1; alt_req = 1;
        #1;
        chk(alt_rdy == 0, "R8", "processor wins", alt_rdy, 0);
        @(negedge clk);
        cpu_req = 0;
        chk(cpu_rdy == 0 && alt_rdy == 0, "R8", "busy blocks both", {cpu_rdy, alt_rdy}, 0);
        alt_req = 0;
        repeat (10) @(negedge clk);
        chk(loc_cnt == l0 + 2, "R8", "alt not served", loc_cnt, l0 + 2);

        // random traffic
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < NUM_RGN; i++) begin
                automatic int sz = ($urandom % 13) + 4;
                set_rgn(i, $urandom, ~((32'h1 << sz) - 1), FLAG_W'($urandom));
            end
            for (int k = 0; k < 10; k++) begin
                automatic int sel = $urandom % 5;
                automatic logic [ADDR_W-1:0] a = (sel < NUM_RGN) ?
                    (b_base[sel] ^ ($urandom & ~b_mask[sel])) : $urandom;
                automatic logic w = $urandom % 2, s = $urandom % 2;
                automatic logic [DATA_W-1:0] d = $urandom;
                automatic logic exp_v = ref_viol(a, w, s);
                cpu_access(a, w, s, 0, d, got, err, rd, lat);
                chk(got && err == exp_v, exp_v ? "R4" : "R3", "random verdict", err, exp_v);
                if (!exp_v) begin
                    chk(rd == (w ? shb_model(a) : shb_model(a)) && last_saddr == a &&
                        last_swrite == w && last_swdata == (w ? d : 0),
                        "R5", "random forward", last_saddr, a);
                end
            end
        end

        // R9 soft reset
        set_mode(1, 1);
        set_rgn(0, 32'h7000_0000, 32'hFFFF_0000, 4'b0011);
        hold_tgt = 1;
        @(negedge clk);
        cpu_req = 1; cpu_addr = 32'h1200_0000; cpu_write = 0; cpu_local = 0;
        @(negedge clk);
        cpu_req = 0;
        repeat (4) @(negedge clk);
        chk(cpu_rdy == 0, "R8", "waiting for target", cpu_rdy, 0);
        a0 = ack_cnt;
        soft_rst = 1;
        @(negedge clk);
        soft_rst = 0;
        chk(cpu_rdy == 1, "R9", "idle after soft reset", cpu_rdy, 1);
        repeat (5) @(negedge clk);
        chk(ack_cnt == a0, "R9", "pending dropped", ack_cnt, a0);
        hold_tgt = 0;
        cpu_access(32'h7000_0010, 1, 1, 0, 32'h3, got, err, rd, lat);
        chk(err, "R9", "region kept", err, 1);
        alt_access(32'h6000_0100, 0, 0, got, rd);
        chk(got, "R9", "slave mode kept", got, 1);
        @(negedge clk);
        cpu_req = 1; cpu_local = 1; cpu_write = 1;
        @(negedge clk);
        cpu_req = 0; cpu_local = 0;
        chk(shb_mirror == 1, "R9", "show mode kept", shb_mirror, 1);

        // R10 hard reset clears
        do_hard_reset();
        cpu_access(32'h7000_0010, 1, 1, 0, 32'h3, got, err, rd, lat);
        chk(got && !err, "R10", "regions cleared", {got, err}, 2'b10);
        chk(alt_rdy == 0, "R10", "master mode", alt_rdy, 0);
        m0 = mir_cnt;
        @(negedge clk);
        cpu_req = 1; cpu_local = 1;
        @(negedge clk);
        cpu_req = 0; cpu_local = 0;
        chk(!shb_req && mir_cnt == m0, "R10", "show off", shb_req, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule